// File: doc/BRIEF.md
# Two-Phase Microcode Sequencer

This block steps through a control store of 64-bit microwords that sits in a synchronous on-chip array. The array is filled through a plain write port, normally while the block is held in reset. Each microword is split into two groups. The upper 40 bits are level controls that pick data paths and must be steady before anything latches. The lower 24 bits are strobes that latch through those paths. A microcycle lasts two clocks. On the first edge the level group is registered onto `level_o`. On the second edge the strobe group is registered onto `strobe_o` for one clock. A single microword can therefore both set up a path and latch through it.

The block holds an 8-bit instruction register (IR) that loads an opcode from an incoming byte stream. It also computes the next microaddress. By default the address increments. A jump strobe replaces the increment with either the 8-bit jump field of the microword or the opcode itself, which gives a 256-entry dispatch space.

The opcode stream follows valid/ready rules. `bus_ready_o` is high only during the strobe phase of a microword that requests an IR load. A byte is taken on a clock edge where `bus_valid_i` and `bus_ready_o` are both high. While `bus_valid_i` is low, the microword stalls in its strobe phase. During a stall no strobe is issued, the level outputs hold, and the microaddress holds. Back-pressure on the producer therefore lasts until the sequencer next reaches such a microword.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high), `strobe_o`, `level_o`, `uaddr_o`, `ir_o` and `bus_ready_o` are all zero on the clock after it is sampled.
- R2: On the first clock edge after `rst` falls, `level_o` takes bits [63:24] of word 0. After that, each microcycle takes exactly two clock edges: a setup edge followed by a strobe edge.
- R3: `strobe_o` carries bits [23:0] of the current word for exactly one clock. That clock starts on the strobe edge, one clock after `level_o` took the same word's bits [63:24]. At all other times `strobe_o` is zero.
- R4: `level_o` changes only on setup edges. It stays unchanged through the strobe phase, including any stall.
- R5: When word bit 0 (jump) is clear, the next microaddress is the current one plus 1, modulo 256, so 255 is followed by 0.
- R6: When word bit 0 is set and word bit 24 (jump source) is high, the next microaddress is word bits [32:25].
- R7: When word bit 0 is set, word bit 24 is low and word bit 4 is clear, the next microaddress is the value of `ir_o`.
- R8: When word bit 4 (IR load) is set, `bus_ready_o` is high throughout that word's strobe phase. Each clock with `bus_valid_i` low adds one stall clock, during which `strobe_o` is zero and `uaddr_o` and `ir_o` hold. On the edge where `bus_valid_i` is high, `ir_o` takes `bus_data_i` and the strobes fire.
- R9: When word bits 0 and 4 are both set and bit 24 is low, the next microaddress is the byte accepted on that same edge, not the previous IR value.
- R10: A clock edge with `store_we_i` high writes `store_wdata_i` to entry `store_addr_i`. Later microcycles play the written content.
- R11: `ir_o` keeps its value in every microcycle whose word has bit 4 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| store_we_i | input | 1 | Control store write enable |
| store_addr_i | input | 8 | Control store write address |
| store_wdata_i | input | 64 | Control store write data |
| bus_valid_i | input | 1 | Opcode byte valid |
| bus_ready_o | output | 1 | Sequencer accepts an opcode byte |
| bus_data_i | input | 8 | Opcode byte |
| level_o | output | 40 | Registered level control group (word bits 63:24) |
| strobe_o | output | 24 | One-clock strobe group (word bits 23:0) |
| uaddr_o | output | 8 | Current microaddress |
| ir_o | output | 8 | Instruction register |

## Verification
The two functions that can fall on the same edge are the opcode load into the IR and a jump sourced from the IR. When they coincide, the dispatch must use the byte accepted on that edge rather than the stale opcode. A fixed program chains a fetch word, a plain dispatch word and a combined fetch-and-dispatch word. The opcodes it feeds lead to a field jump at address 255 and an increment wrap back to 0. This runs while `bus_valid_i` toggles at random, so the combined word is also hit after one or more stall clocks. A per-clock reference model in the bench predicts every output. A random control store then exercises the same coincidence from arbitrary addresses.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  // Strobe group bit positions decoded inside the sequencer.
  localparam int JUMP_BIT  = 0;
  localparam int IRLD_BIT  = 4;
  // Level group bit positions (relative to the level group's LSB).
  localparam int SRC_BIT   = 0;
  localparam int FIELD_LSB = 1;

  typedef enum logic {
    PH_SETUP = 1'b0,
    PH_FIRE  = 1'b1
  } phase_e;
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
  parameter int AW = 8,
  parameter int WW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // Synchronous array: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucseq_ir_reg.sv
module ucseq_ir_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ucseq_addr_gen.sv
module ucseq_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          jump_en,
  input  logic          src_field,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] ir_q,
  input  logic          ir_load_en,
  input  logic [AW-1:0] bus_data,
  output logic [AW-1:0] uaddr_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [AW-1:0] uaddr_q;
  logic [AW-1:0] target;
  logic [AW-1:0] next_addr;

  // The opcode being accepted this edge bypasses the IR register.
  always_comb begin
    if (src_field)       target = field;
    else if (ir_load_en) target = bus_data;
    else                 target = ir_q;
    next_addr = jump_en ? target : uaddr_q + 1'b1;
  end

  // Read address leads the register so the array output is ready by the setup edge.
  always_comb begin
    if (rst)          rd_addr_o = '0;
    else if (step_en) rd_addr_o = next_addr;
    else              rd_addr_o = uaddr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          uaddr_q <= '0;
    else if (step_en) uaddr_q <= next_addr;
  end

  assign uaddr_o = uaddr_q;

  a_r5_seq_increment: assert property (@(posedge clk) disable iff (rst)
    (step_en && !jump_en) |=> uaddr_q == AW'($past(uaddr_q) + 1'b1));

  a_r6_field_target: assert property (@(posedge clk) disable iff (rst)
    (step_en && jump_en && src_field) |=> uaddr_q == $past(field));

  a_r9_bypass_target: assert property (@(posedge clk) disable iff (rst)
    (step_en && jump_en && !src_field && ir_load_en) |=> uaddr_q == $past(bus_data));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int UADDR_W  = 8,
  parameter int STROBE_W = 24,
  parameter int LEVEL_W  = 40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        store_we_i,
  input  logic [UADDR_W-1:0]          store_addr_i,
  input  logic [STROBE_W+LEVEL_W-1:0] store_wdata_i,
  input  logic                        bus_valid_i,
  output logic                        bus_ready_o,
  input  logic [UADDR_W-1:0]          bus_data_i,
  output logic [LEVEL_W-1:0]          level_o,
  output logic [STROBE_W-1:0]         strobe_o,
  output logic [UADDR_W-1:0]          uaddr_o,
  output logic [UADDR_W-1:0]          ir_o
);
  import ucseq_pkg::*;

  localparam int WORD_W = STROBE_W + LEVEL_W;

  phase_e               phase_q;
  logic [WORD_W-1:0]    word;
  logic [UADDR_W-1:0]   rd_addr;
  logic [LEVEL_W-1:0]   level_q;
  logic [STROBE_W-1:0]  pend_q;
  logic [STROBE_W-1:0]  strobe_q;
  logic                 ir_req;
  logic                 stall;
  logic                 fire_go;
  logic                 ir_load_en;
  logic                 jump_en;

  ucseq_store #(.AW(UADDR_W), .WW(WORD_W)) u_store (
    .clk   (clk),
    .we    (store_we_i),
    .waddr (store_addr_i),
    .wdata (store_wdata_i),
    .raddr (rd_addr),
    .rdata (word)
  );

  assign ir_req     = pend_q[IRLD_BIT];
  assign stall      = (phase_q == PH_FIRE) && ir_req && !bus_valid_i;
  assign fire_go    = (phase_q == PH_FIRE) && !stall;
  assign ir_load_en = fire_go && ir_req;
  assign jump_en    = fire_go && pend_q[JUMP_BIT];
  assign bus_ready_o = (phase_q == PH_FIRE) && ir_req;

  ucseq_ir_reg #(.W(UADDR_W)) u_ir (
    .clk  (clk),
    .rst  (rst),
    .load (ir_load_en),
    .din  (bus_data_i),
    .q    (ir_o)
  );

  ucseq_addr_gen #(.AW(UADDR_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .step_en    (fire_go),
    .jump_en    (jump_en),
    .src_field  (level_q[SRC_BIT]),
    .field      (level_q[FIELD_LSB +: UADDR_W]),
    .ir_q       (ir_o),
    .ir_load_en (ir_load_en),
    .bus_data   (bus_data_i),
    .uaddr_o    (uaddr_o),
    .rd_addr_o  (rd_addr)
  );

  // Setup edge: register level group, stash strobes. Fire edge: pulse strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_SETUP;
      level_q  <= '0;
      pend_q   <= '0;
      strobe_q <= '0;
    end else if (phase_q == PH_SETUP) begin
      level_q  <= word[WORD_W-1:STROBE_W];
      pend_q   <= word[STROBE_W-1:0];
      strobe_q <= '0;
      phase_q  <= PH_FIRE;
    end else if (stall) begin
      strobe_q <= '0;
    end else begin
      strobe_q <= pend_q;
      phase_q  <= PH_SETUP;
    end
  end

  assign level_o  = level_q;
  assign strobe_o = strobe_q;

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (strobe_o != '0) |=> (strobe_o == '0));

  a_r4_level_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_o) |-> (phase_q == PH_FIRE));

  a_r8_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    (bus_ready_o && !bus_valid_i) |=> ($stable(uaddr_o) && $stable(ir_o) && strobe_o == '0));
endmodule

// File: tb/sim_ucode_sequencer.sv
`timescale 1ns/1ps
module sim_ucode_sequencer;
  localparam int AW = 8;
  localparam int SW = 24;
  localparam int LW = 40;
  localparam int WW = SW + LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          store_we = 1'b0;
  logic [AW-1:0] store_addr = '0;
  logic [WW-1:0] store_wdata = '0;
  logic          bus_valid = 1'b0;
  logic          bus_ready;
  logic [AW-1:0] bus_data = '0;
  logic [LW-1:0] level;
  logic [SW-1:0] strobe;
  logic [AW-1:0] uaddr;
  logic [AW-1:0] ir;

  always #2 clk = ~clk;

  ucode_sequencer #(.UADDR_W(AW), .STROBE_W(SW), .LEVEL_W(LW)) u0 (
    .clk(clk), .rst(rst), .store_we_i(store_we), .store_addr_i(store_addr),
    .store_wdata_i(store_wdata), .bus_valid_i(bus_valid), .bus_ready_o(bus_ready),
    .bus_data_i(bus_data), .level_o(level), .strobe_o(strobe), .uaddr_o(uaddr), .ir_o(ir)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model state
  logic [WW-1:0] m_mem [256];
  bit            m_fire;
  logic [LW-1:0] m_level;
  logic [SW-1:0] m_pend;
  logic [SW-1:0] m_strobe;
  logic [AW-1:0] m_addr;
  logic [AW-1:0] m_ir;
  string         m_rule = "R2";

  function automatic logic [AW-1:0] next_addr(logic [SW-1:0] pend, logic [LW-1:0] lev,
                                               logic [AW-1:0] cur, logic [AW-1:0] old_ir,
                                               logic [AW-1:0] byte_in);
    if (!pend[0])     return cur + 8'd1;         // R5
    else if (lev[0])  return lev[8:1];           // R6
    else if (pend[4]) return byte_in;            // R9
    else              return old_ir;             // R7
  endfunction

  function automatic string rule_of(logic [SW-1:0] pend, logic [LW-1:0] lev);
    if (!pend[0])     return "R5";
    else if (lev[0])  return "R6";
    else if (pend[4]) return "R9";
    else              return "R7";
  endfunction

  task automatic model_edge();
    logic [AW-1:0] old_ir;
    if (rst) begin
      m_fire = 0; m_level = '0; m_pend = '0; m_strobe = '0; m_addr = '0; m_ir = '0;
      m_rule = "R1";
    end else if (!m_fire) begin
      m_level  = m_mem[m_addr][WW-1:SW];
      m_pend   = m_mem[m_addr][SW-1:0];
      m_strobe = '0;
      m_fire   = 1;
    end else if (m_pend[4] && !bus_valid) begin
      m_strobe = '0;
      m_rule   = "R8";
    end else begin
      m_strobe = m_pend;
      old_ir   = m_ir;
      if (m_pend[4]) m_ir = bus_data;
      m_rule   = rule_of(m_pend, m_level);
      m_addr   = next_addr(m_pend, m_level, m_addr, old_ir, bus_data);
      m_fire   = 0;
    end
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (rst) begin
      chk("R1", "level_o", 64'(level), 64'd0);
      chk("R1", "strobe_o", 64'(strobe), 64'd0);
      chk("R1", "uaddr_o", 64'(uaddr), 64'd0);
      chk("R1", "ir_o", 64'(ir), 64'd0);
      chk("R1", "bus_ready_o", 64'(bus_ready), 64'd0);
    end else begin
      chk("R2 R4 R10", "level_o", 64'(level), 64'(m_level));
      chk("R3", "strobe_o", 64'(strobe), 64'(m_strobe));
      chk(m_rule, "uaddr_o", 64'(uaddr), 64'(m_addr));
      chk("R8 R11", "ir_o", 64'(ir), 64'(m_ir));
      chk("R8", "bus_ready_o", 64'(bus_ready), 64'(m_fire && m_pend[4]));
    end
  endtask

  function automatic logic [WW-1:0] rand_word();
    logic [WW-1:0] w;
    w = {$urandom, $urandom};
    w[0]  = ($urandom % 4) == 0;
    w[4]  = ($urandom % 4) == 0;
    w[24] = $urandom % 2;
    return w;
  endfunction

  // Fixed program: 0 -> 1(fetch) -> 2(dispatch IR) -> 0x3C(fetch+dispatch) -> 0xF0(field 0xFF) -> 0xFF -> 0
  function automatic logic [WW-1:0] dir_word(int a);
    logic [WW-1:0] w;
    w = {$urandom, $urandom};
    w[0] = 0; w[4] = 0; w[24] = 0;
    case (a)
      1:    w[4] = 1;
      2:    w[0] = 1;
      8'h3C: begin w[0] = 1; w[4] = 1; end
      8'hF0: begin w[0] = 1; w[24] = 1; w[32:25] = 8'hFF; end
      default: ;
    endcase
    return w;
  endfunction

  task automatic load_store(bit directed);
    rst = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      store_we    = 1'b1;
      store_addr  = AW'(a);
      store_wdata = directed ? dir_word(a) : rand_word();
      m_mem[a]    = store_wdata;
      @(posedge clk);
      model_edge();
    end
    @(negedge clk);
    store_we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();                            // R1 reset state
    end
    rst = 1'b0;
    @(posedge clk);
    model_edge();
  endtask

  task automatic run(int n, bit directed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (done) return;
      bus_valid = directed ? ($urandom % 2) : (($urandom % 10) < 7);
      if (directed && m_addr == 8'd1)       bus_data = 8'h3C;   // R7 dispatch target
      else if (directed && m_addr == 8'h3C) bus_data = 8'hF0;   // R9 bypass target
      else                                  bus_data = AW'($urandom);
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin
    void'($urandom(32'hC0DE5EED));
    m_fire = 0; m_level = '0; m_pend = '0; m_strobe = '0; m_addr = '0; m_ir = '0;
    load_store(1'b1);
    run(1500, 1'b1);
    load_store(1'b0);
    run(3000, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog run actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule